// File: doc/BRIEF.md
# Eight-pin GPIO port register unit

This block holds the control state for a small group of general-purpose pins behind a plain word-addressed register interface. The interface has an address, a write strobe, write data and read data. Each pin has a two-bit mode that chooses its driver: input only, push-pull, open-drain or quasi-bidirectional. Each pin also has an output bit, a protect bit that blocks writes to that output bit, and a switch that turns off its digital input path. Pin inputs pass through a synchronizer before they are read.

Software can also reach a single pin through its own alias word. A write to an alias word changes only that pin's output bit, so no read-modify-write of the whole port is needed. A read of an alias word returns that pin's current input level in bit 0.

Read data is combinational from the address. Writes take effect at the rising clock edge where the write strobe is high. The pad-side outputs follow the stored registers through combinational logic.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the mode, input-disable, output and protect registers all read 0, and every pin has its output enable low.
- R2: The mode of pin n is bits [2n+1:2n] of the word at offset 0x00. Code 00 (input) keeps the pin's output enable low.
- R3: Code 01 (push-pull) sets the pin's output enable high, with the pin output equal to its output bit.
- R4: Code 10 (open-drain) and code 11 (quasi-bidirectional) drive the pin low (enable 1, output 0) when its output bit is 0. They release the pin (enable 0) when the output bit is 1, so a high level is never actively driven.
- R5: The output register sits at offset 0x08, bits [7:0]. A write there loads it, and it reads back unchanged.
- R6: The protect register sits at offset 0x0C. An output bit whose protect bit is 1 keeps its value when the output register is written, while unprotected bits update.
- R7: The input-disable bits sit at bits [23:16] of offset 0x04, with bit 16+n belonging to pin n. A set bit makes pin n read as 0 everywhere its level is reported.
- R8: The pin level register at offset 0x10 shows each pin's synchronized input level in bits [7:0]. Writes to it change no register.
- R9: The alias word of pin n is at offset 0x200 + 4n. Writing it copies wdata bit 0 into output bit n and leaves every other output bit unchanged.
- R10: Reading the alias word of pin n returns that pin's level in bit 0 and zeros in all other bits.
- R11: An alias write to a pin whose protect bit is 1 leaves that output bit unchanged.
- R12: A change on the pin inputs first shows in the level register after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 10 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| pin_in | input | 8 | Raw pin input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |

## Verification
The bench builds the block with its default parameters: eight pins, a 10-bit address, alias words starting at 0x200 and a two-stage synchronizer. With eight pins, one mixed mode word puts all four driver codes side by side. The alias region is also eight words long, so an index decode error on pin 5 or pin 2 shows up as a changed neighbour bit. With two stages, the one-cycle-early read lands exactly on the cycle that separates a correct synchronizer from a short one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_INPUT     = 2'b00,
      PM_PUSHPULL  = 2'b01,
      PM_OPENDRAIN = 2'b10,
      PM_QUASI     = 2'b11
   } pin_mode_e;

   // word offsets of the port registers (bytes)
   localparam int OFF_MODE  = 'h00;
   localparam int OFF_INDIS = 'h04;
   localparam int OFF_DOUT  = 'h08;
   localparam int OFF_PROT  = 'h0C;
   localparam int OFF_LEVEL = 'h10;

   // bit position of the first input-disable bit in its word
   localparam int INDIS_LSB = 16;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      if (STAGES < 2) $error("gpio_in_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("gpio_in_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_port_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NPINS-1:0] mode_bits,
   input  logic [NPINS-1:0]   dout,
   output logic [NPINS-1:0]   pin_oe,
   output logic [NPINS-1:0]   pin_out
);

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         pin_mode_e md;
         assign md = pin_mode_e'(mode_bits[2*i +: 2]);

         always_comb begin
            unique case (md)
               PM_INPUT: begin
                  pin_oe[i]  = 1'b0;
                  pin_out[i] = 1'b0;
               end
               PM_PUSHPULL: begin
                  pin_oe[i]  = 1'b1;
                  pin_out[i] = dout[i];
               end
               default: begin
                  // open-drain and quasi: pull low only, release on 1
                  pin_oe[i]  = ~dout[i];
                  pin_out[i] = 1'b0;
               end
            endcase
         end

         // R4
         no_high_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == PM_OPENDRAIN || md == PM_QUASI) |-> !(pin_oe[i] && pin_out[i]));

         // R2
         input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == PM_INPUT) |-> !pin_oe[i]);
      end
   endgenerate

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
   import gpio_port_pkg::*;
#(
   parameter int NPINS      = 8,
   parameter int AW         = 10,
   parameter int DW         = 32,
   parameter int ALIAS_BASE = 'h200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      addr,
   input  logic               wr_en,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   input  logic [NPINS-1:0]   pin_sync,
   output logic [2*NPINS-1:0] mode_bits,
   output logic [NPINS-1:0]   dout
);

   localparam int IW = $clog2(NPINS);
   localparam logic [AW-1:0] A_MODE  = AW'(OFF_MODE);
   localparam logic [AW-1:0] A_INDIS = AW'(OFF_INDIS);
   localparam logic [AW-1:0] A_DOUT  = AW'(OFF_DOUT);
   localparam logic [AW-1:0] A_PROT  = AW'(OFF_PROT);
   localparam logic [AW-1:0] A_LEVEL = AW'(OFF_LEVEL);
   localparam logic [AW-1:0] A_ALIAS = AW'(ALIAS_BASE);
   localparam logic [AW-1:0] A_SPAN  = AW'(4 * NPINS);

   logic [2*NPINS-1:0] mode_q;
   logic [NPINS-1:0]   indis_q, dout_q, prot_q, dout_nxt, level;
   logic [AW-1:0]      alias_rel;
   logic               alias_hit;
   logic [IW-1:0]      alias_idx;

   assign alias_rel = addr - A_ALIAS;
   assign alias_hit = (addr >= A_ALIAS) && (alias_rel < A_SPAN) && (alias_rel[1:0] == 2'b00);
   assign alias_idx = alias_rel[IW+1:2];
   assign level     = pin_sync & ~indis_q;

   always_comb begin
      dout_nxt = dout_q;
      if (wr_en && addr == A_DOUT)
         dout_nxt = (dout_q & prot_q) | (wdata[NPINS-1:0] & ~prot_q);
      else if (wr_en && alias_hit && !prot_q[alias_idx])
         dout_nxt[alias_idx] = wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         indis_q <= '0;
         dout_q  <= '0;
         prot_q  <= '0;
      end else begin
         dout_q <= dout_nxt;
         if (wr_en && addr == A_MODE)  mode_q  <= wdata[2*NPINS-1:0];
         if (wr_en && addr == A_INDIS) indis_q <= wdata[INDIS_LSB +: NPINS];
         if (wr_en && addr == A_PROT)  prot_q  <= wdata[NPINS-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (alias_hit)            rdata[0] = level[alias_idx];
      else if (addr == A_MODE)  rdata[2*NPINS-1:0] = mode_q;
      else if (addr == A_INDIS) rdata[INDIS_LSB +: NPINS] = indis_q;
      else if (addr == A_DOUT)  rdata[NPINS-1:0] = dout_q;
      else if (addr == A_PROT)  rdata[NPINS-1:0] = prot_q;
      else if (addr == A_LEVEL) rdata[NPINS-1:0] = level;
   end

   assign mode_bits = mode_q;
   assign dout      = dout_q;

   // R6
   protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DOUT) |=> ((dout_q & $past(prot_q)) == ($past(dout_q) & $past(prot_q))));

   // R8
   level_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_LEVEL) |=> ($stable(dout_q) && $stable(mode_q) && $stable(prot_q) && $stable(indis_q)));

   // R9
   alias_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && alias_hit) |=> ($countones(dout_q ^ $past(dout_q)) <= 1));

   // R7
   disabled_reads_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_LEVEL) |-> ((rdata[NPINS-1:0] & indis_q) == '0));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int AW          = 10,
   parameter int DW          = 32,
   parameter int ALIAS_BASE  = 'h200,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             wr_en,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out
);

   localparam int MODE_W = 2 * NPINS;

   initial begin
      if (NPINS < 2 || NPINS > 16)       $error("gpio_port_regs: NPINS must be 2..16");
      if (DW != 32)                      $error("gpio_port_regs: DW must be 32");
      if (MODE_W > DW)                   $error("gpio_port_regs: mode field exceeds word");
      if (ALIAS_BASE % 4 != 0)           $error("gpio_port_regs: ALIAS_BASE must be word aligned");
      if (ALIAS_BASE + 4 * NPINS > (1 << AW))
                                         $error("gpio_port_regs: alias region exceeds address space");
      if (ALIAS_BASE <= OFF_LEVEL)       $error("gpio_port_regs: alias region overlaps registers");
   end

   logic [NPINS-1:0]  pin_sync;
   logic [MODE_W-1:0] mode_bits;
   logic [NPINS-1:0]  dout;

   gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   gpio_reg_file #(.NPINS(NPINS), .AW(AW), .DW(DW), .ALIAS_BASE(ALIAS_BASE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .pin_sync  (pin_sync),
      .mode_bits (mode_bits),
      .dout      (dout)
   );

   gpio_pad_ctrl #(.NPINS(NPINS)) u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_bits (mode_bits),
      .dout      (dout),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out)
   );

   // R3
   pushpull_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bits[1:0] == 2'b01) |-> (pin_oe[0] && pin_out[0] == dout[0]));

endmodule

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

   typedef struct packed {
      logic [15:0] mode;
      logic [7:0]  dout;
      logic [7:0]  oe;
      logic [7:0]  out;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{16'h0000, 8'hFF, 8'h00, 8'h00},   // R2 all inputs
      '{16'h5555, 8'hA5, 8'hFF, 8'hA5},   // R3 all push-pull
      '{16'hAAAA, 8'h0F, 8'hF0, 8'h00},   // R4 all open-drain
      '{16'hFFFF, 8'h3C, 8'hC3, 8'h00},   // R4 all quasi
      '{16'h55E4, 8'hF5, 8'hFA, 8'hF0}    // R2 R3 R4 mixed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_oe, pin_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_port_regs u_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(10'h000, v); chk("R1 mode", v, 32'h0);
      rd(10'h004, v); chk("R1 indis", v, 32'h0);
      rd(10'h008, v); chk("R1 dout", v, 32'h0);
      rd(10'h00C, v); chk("R1 prot", v, 32'h0);
      chk("R1 oe", {24'h0, pin_oe}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         wr(10'h000, {16'h0, VECS[k].mode});
         wr(10'h008, {24'h0, VECS[k].dout});
         rd(10'h008, v);
         chk("R5 dout readback", v, {24'h0, VECS[k].dout});
         chk("R2/R3/R4 oe", {24'h0, pin_oe}, {24'h0, VECS[k].oe});
         chk("R2/R3/R4 out", {24'h0, pin_out}, {24'h0, VECS[k].out});
      end

      // R6 protect filter on word write
      wr(10'h008, 32'h0000_0000);
      wr(10'h00C, 32'h0000_000F);
      wr(10'h008, 32'h0000_00FF);
      rd(10'h008, v); chk("R6 protected bits held", v, 32'h0000_00F0);
      wr(10'h00C, 32'h0);

      // R9 alias write touches one bit
      wr(10'h008, 32'h0);
      wr(10'h214, 32'h1);
      rd(10'h008, v); chk("R9 alias set pin5", v, 32'h0000_0020);
      wr(10'h214, 32'h0);
      rd(10'h008, v); chk("R9 alias clear pin5", v, 32'h0);
      wr(10'h008, 32'hFF);
      wr(10'h208, 32'hFFFF_FFFE);
      rd(10'h008, v); chk("R9 alias bit0 only pin2", v, 32'h0000_00FB);

      // R11 alias write blocked by protect
      wr(10'h008, 32'h0);
      wr(10'h00C, 32'h0000_0008);
      wr(10'h20C, 32'h1);
      rd(10'h008, v); chk("R11 protected alias", v, 32'h0);
      wr(10'h00C, 32'h0);

      // R12 synchronizer latency
      @(negedge clk);
      pin_in = 8'h96;
      @(negedge clk);
      rd(10'h010, v); chk("R12 not after one edge", v, 32'h0);
      @(negedge clk);
      rd(10'h010, v); chk("R12 after two edges", v, 32'h0000_0096);

      // R8 level register ignores writes
      wr(10'h010, 32'hFFFF_FFFF);
      rd(10'h010, v); chk("R8 level unchanged", v, 32'h0000_0096);
      rd(10'h008, v); chk("R8 dout unchanged", v, 32'h0);

      // R7 input disable
      wr(10'h004, 32'h0003_0000);
      rd(10'h004, v); chk("R7 indis readback", v, 32'h0003_0000);
      rd(10'h010, v); chk("R7 disabled pins low", v, 32'h0000_0094);

      // R10 alias reads
      rd(10'h208, v); chk("R10 alias read pin2", v, 32'h1);
      rd(10'h204, v); chk("R10 alias read disabled pin1", v, 32'h0);
      rd(10'h21C, v); chk("R10 alias read pin7", v, 32'h1);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule